// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec for 16-bit Words

This block guards 16-bit words with a Hamming code that adds five check bits, so each word is kept as 21 bits. Encoding and decoding share one input beat. A caller writing to storage presents the data word and takes the five check bits to store beside it. A caller reading from storage presents the fetched data and the fetched check bits. The block then returns the repaired word and two status flags.

The code places each check bit at a power-of-two position within the 21-bit word and spreads the data bits over the other positions. On a read, the block recomputes the check bits from the fetched data and XORs them with the stored ones. The result is a syndrome whose value is the position of the bit that flipped. A syndrome that names a data position inverts that data bit. A syndrome that names a check-bit position leaves the data as it was. A syndrome above 21 names no position, so it is reported as uncorrectable. All outputs are registered one clock after the input beat. The block corrects single errors only. It does not detect double errors.

Top module: `hsec_codec`

## Requirements
- R1: `check_out` carries five check bits computed from `in_data`: bit 0 (weight 1) is the XOR of data bits D1,D2,D4,D5,D7,D9,D11,D12,D14,D16; bit 1 (weight 2) of D1,D3,D4,D6,D7,D10,D11,D13,D14; bit 2 (weight 4) of D2,D3,D4,D8,D9,D10,D11,D15,D16; bit 3 (weight 8) of D5 to D11; bit 4 (weight 16) of D12 to D16, where Dn is `in_data[n-1]`. `in_check` uses the same bit order.
- R2: When `in_check` equals the check bits of `in_data` (syndrome zero), `data_out` equals `in_data` and both flags are low.
- R3: The syndrome is `in_check` XOR the recomputed check bits, read as a binary number. Data bit Dn occupies code position 3,5,6,7,9,10,11,12,13,14,15,17,18,19,20,21 for n = 1 to 16. A syndrome equal to one of these positions inverts exactly that data bit and raises `corrected`.
- R4: A syndrome of 1, 2, 4, 8 or 16 (a flipped check bit) leaves `data_out` equal to `in_data` and raises `corrected`, with `uncorrectable` low.
- R5: A syndrome from 22 to 31 raises `uncorrectable`, keeps `corrected` low and passes `in_data` through unchanged.
- R6: `out_valid`, `data_out`, `check_out` and both flags appear one clock after the input beat. `out_valid` equals the previous cycle's `in_valid`. A synchronous active-low reset clears `out_valid` and both flags.
- R7: `corrected` and `uncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 16 | Data to encode, or fetched data to check |
| in_check | input | 5 | Fetched check bits (bit k has weight 2^k) |
| out_valid | output | 1 | Registered result valid |
| data_out | output | 16 | Repaired (or passed-through) data |
| check_out | output | 5 | Check bits of `in_data` for storing |
| corrected | output | 1 | A single flipped bit was located |
| uncorrectable | output | 1 | Syndrome names no code position |

## Verification
Encoding and repair happen in the same beat, because a single check-bit generator serves both. `check_out` is always the check bits of the raw `in_data`, even when that data carries a flipped bit and `data_out` is the repaired word. The bench flips each data bit of several words in turn and compares both outputs of that one beat with a model that uses the listed bit masks. The mask model gives the check bits of the faulty word for `check_out`, and the original word for `data_out`. Back-to-back beats with mixed syndrome classes confirm that the flags from one beat never carry into the next.

// File: rtl/hsec_pkg.sv
// Package: shared constants and elaboration-time helpers for the Hamming codec.
// Assumes code positions are numbered from 1, with check bits at powers of two.
package hsec_pkg;

    localparam int MAX_POS = 1024;

    // True when p is a power of two (a check-bit position).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Smallest k with 2^k - 1 >= dw + k.
    function automatic int chk_width(input int dw);
        int k;
        k = 1;
        while (((1 << k) - 1) < (dw + k)) k++;
        return k;
    endfunction

    // Code position (1-based) of data bit index j (0-based).
    function automatic int data_pos(input int j);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int p = 1; p < MAX_POS; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j && pos == 0) pos = p;
                cnt++;
            end
        end
        return pos;
    endfunction

    // Mask of data bits covered by check bit k.
    function automatic logic [255:0] cover_mask(input int k, input int dw);
        logic [255:0] m;
        m = '0;
        for (int j = 0; j < dw; j++) begin
            if (((data_pos(j) >> k) & 1) == 1) m[j] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hsec_chk_gen.sv
// Module: check-bit generator. Purely combinational.
// Check bit k is the parity of every data bit whose code position has bit k set.
// Assumes DATA_W <= 256.
module hsec_chk_gen #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = hsec_pkg::chk_width(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);

    // One parity tree per check bit, with its mask fixed at elaboration.
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [255:0] FULL = hsec_pkg::cover_mask(k, DATA_W);
        assign chk[k] = ^(data & FULL[DATA_W-1:0]);
    end

endmodule

// File: rtl/hsec_fix.sv
// Module: syndrome decoder and data repair. Purely combinational.
// A syndrome naming a data position flips that bit. One naming a check
// position leaves the data alone. One past the code length is uncorrectable.
module hsec_fix #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = hsec_pkg::chk_width(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  syndrome,
    output logic [DATA_W-1:0] fixed,
    output logic              corrected,
    output logic              uncorrectable
);

    localparam int             CODE_W = DATA_W + CHK_W;
    localparam logic [CHK_W-1:0] LAST = CHK_W'(CODE_W);

    logic [DATA_W-1:0] flip;

    // One position comparator per data bit.
    for (genvar j = 0; j < DATA_W; j++) begin : g_flip
        localparam logic [CHK_W-1:0] POS = CHK_W'(hsec_pkg::data_pos(j));
        assign flip[j] = (syndrome == POS);
    end

    // Classify the syndrome and apply the single-bit repair.
    always_comb begin
        uncorrectable = (syndrome > LAST);
        corrected     = (syndrome != '0) && !uncorrectable;
        fixed         = data ^ flip;
    end

endmodule

// File: rtl/hsec_codec.sv
// Module: top of the SEC Hamming codec. One generator serves both the encode
// result (check_out) and the syndrome for repair. All outputs are registered
// one clock after the input beat. Synchronous active-low reset.
module hsec_codec #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = hsec_pkg::chk_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  in_check,
    output logic              out_valid,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  check_out,
    output logic              corrected,
    output logic              uncorrectable
);

    logic [CHK_W-1:0]  recomp;
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] fixed;
    logic              corr_c;
    logic              unc_c;

    hsec_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_gen (
        .data (in_data),
        .chk  (recomp)
    );

    // Syndrome: stored check bits against recomputed ones.
    assign syndrome = in_check ^ recomp;

    hsec_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
        .data          (in_data),
        .syndrome      (syndrome),
        .fixed         (fixed),
        .corrected     (corr_c),
        .uncorrectable (unc_c)
    );

    // Output register stage: clear on reset, otherwise capture every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            data_out      <= '0;
            check_out     <= '0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            data_out      <= fixed;
            check_out     <= recomp;
            corrected     <= corr_c;
            uncorrectable <= unc_c;
        end
    end

    // R6: out_valid follows in_valid one cycle later.
    a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: the two flags are exclusive.
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected && uncorrectable));

    // R2/R4/R5: without a data repair the word passes through untouched.
    a_r5_unc_passes: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unc_c |=> data_out == $past(in_data));

    // R3: a repair changes at most one data bit.
    a_r3_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones(data_out ^ $past(in_data)) <= 1);

    // R1/R2: a clean beat means the stored check bits equal the emitted ones.
    a_r1_clean_match: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_check == recomp |=>
            !corrected && !uncorrectable && check_out == $past(in_check));

endmodule

// File: tb/hsec_codec_tb.sv
// Directed bench for hsec_codec: one task per scenario, mask-based model.
module hsec_codec_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic [4:0]  in_check;
    logic        out_valid;
    logic [15:0] data_out;
    logic [4:0]  check_out;
    logic        corrected;
    logic        uncorrectable;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hsec_codec u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_check      (in_check),
        .out_valid     (out_valid),
        .data_out      (data_out),
        .check_out     (check_out),
        .corrected     (corrected),
        .uncorrectable (uncorrectable)
    );

    // Coverage masks taken from the R1 bit lists (bit n-1 stands for Dn).
    function automatic logic [4:0] model_chk(input logic [15:0] d);
        model_chk[0] = ^(d & 16'hAD5B);
        model_chk[1] = ^(d & 16'h366D);
        model_chk[2] = ^(d & 16'hC78E);
        model_chk[3] = ^(d & 16'h07F0);
        model_chk[4] = ^(d & 16'hF800);
    endfunction

    // Position of data bit index j, per the R3 list.
    function automatic int model_pos(input int j);
        int tbl [16] = '{3,5,6,7,9,10,11,12,13,14,15,17,18,19,20,21};
        return tbl[j];
    endfunction

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one beat, then check every output after the capturing edge.
    task automatic beat(input string req, input logic [15:0] d, input logic [4:0] c);
        logic [4:0]  syn;
        logic [15:0] ed;
        logic        ec;
        logic        eu;
        syn = c ^ model_chk(d);
        ed  = d;
        ec  = 1'b0;
        eu  = 1'b0;
        if (syn > 5'd21) eu = 1'b1;
        else if (syn != 5'd0) begin
            ec = 1'b1;
            for (int j = 0; j < 16; j++) if (model_pos(j) == int'(syn)) ed[j] = ~d[j];
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_check = c;
        @(negedge clk);
        in_valid = 1'b0;
        cmp({req, " data"},  {16'h0, data_out},  {16'h0, ed});
        cmp({req, " check"}, {27'h0, check_out}, {27'h0, model_chk(d)});
        cmp({req, " flags"}, {29'h0, out_valid, corrected, uncorrectable}, {29'h0, 1'b1, ec, eu});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; in_data = 16'hFFFF; in_check = 5'h1F;
        repeat (3) @(negedge clk);
        cmp("R6 reset", {29'h0, out_valid, corrected, uncorrectable}, 32'h0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_clean;
        logic [15:0] words [6] = '{16'h0000, 16'hFFFF, 16'h5039, 16'hA5C3, 16'h8001, 16'h1234};
        foreach (words[i]) beat("R2 clean R1", words[i], model_chk(words[i]));
        cmp("R1 known word", {27'h0, model_chk(16'h5039)}, 32'h1);
    endtask

    task automatic t_data_flip;
        logic [15:0] words [3] = '{16'h5039, 16'h0000, 16'hBEEF};
        foreach (words[i])
            for (int j = 0; j < 16; j++)
                beat("R3 data flip", words[i] ^ (16'h1 << j), model_chk(words[i]));
        // Known case: D5 flipped in storage, stored check 00001, syndrome 01001.
        beat("R3 D5 example", 16'h5029, 5'b00001);
        cmp("R3 D5 repaired", {16'h0, data_out}, {16'h0, 16'h5039});
    endtask

    task automatic t_check_flip;
        for (int k = 0; k < 5; k++)
            beat("R4 check flip", 16'hC3A5, model_chk(16'hC3A5) ^ (5'h1 << k));
    endtask

    task automatic t_bad_syn;
        for (int s = 22; s < 32; s++)
            beat("R5 R7 bad syndrome", 16'h6B2D, model_chk(16'h6B2D) ^ 5'(s));
    endtask

    task automatic t_valid;
        // Back-to-back beats with mixed classes, then an idle cycle.
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h0F0F; in_check = model_chk(16'h0F0F) ^ 5'd31;
        @(negedge clk);
        cmp("R7 unc beat", {30'h0, corrected, uncorrectable}, 32'h1);
        in_data = 16'h0F0F; in_check = model_chk(16'h0F0F);
        @(negedge clk);
        in_valid = 1'b0;
        cmp("R6 flags clear next beat", {29'h0, out_valid, corrected, uncorrectable}, 32'h4);
        @(negedge clk);
        cmp("R6 valid drops", {31'h0, out_valid}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_data_flip();
        t_check_flip();
        t_bad_syn();
        t_valid();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule